// File: doc/BRIEF.md
# Spread-Spectrum Fractional Ratio Modulator

This block supplies the divide ratio for a fractional output clock divider. The ratio has a 12-bit integer part and a 30-bit fraction. A signed correction value is subtracted from the fraction. With spreading off, the block holds that corrected ratio constant. With spreading on, it moves the fraction up and down in a symmetric triangle centred on the corrected ratio, which spreads the spectrum of the divided clock.

The block advances only on output-clock ticks. Each tick is one cycle of `outTick`. A half-period counter measures the triangle legs in ticks, and a ramp accumulator adds or subtracts a programmable step on every tick. Configuration is captured into shadow registers only at points where a change cannot tear the ramp: on every tick while spreading is off, and at triangle turnarounds while it is on. The ratio is a registered value, so it changes on the clock edge that takes a tick. It is saturated to the range that 42 bits can hold, so carries and borrows move into the integer part.

Top module: `ssm_modulator`

## Requirements
- R1: After a synchronous reset, ratioInt and ratioFrac are both 0, the ramp value is 0 and spreading is off until the first tick captures the configuration.
- R2: While spreading is captured as off, each tick captures divInt, divFrac and spreadOffset, the ramp value is 0, and halfPeriod and rampStep do not affect the outputs.
- R3: spreadOffset is a 30-bit two's complement number (bit 29 = 1 means negative) that is subtracted from the concatenated ratio {divInt, divFrac}.
- R4: A tick that finds spreading off while spreadEn is 1 starts the ramp. The ramp value is 0, the direction is up and the leg counter is halfPeriod/2 (floor). So the first leg rises by rampStep on each of the next halfPeriod − halfPeriod/2 ticks.
- R5: While spreading, the leg counter steps 0..halfPeriod−1. The tick that finds it at halfPeriod−1 still applies one step, then reverses the direction and clears the counter. The ramp therefore swings ±halfPeriod·rampStep/2 about the corrected ratio.
- R6: While spreading, the configuration inputs are captured only on a turnaround tick. Until that tick the outputs follow the previously captured values. A turnaround that sees spreadEn = 0 clears the ramp and stops spreading.
- R7: The output ratio is {divInt, divFrac} − offset + ramp, computed over 42 bits. A fraction overflow carries into ratioInt and an underflow borrows from it.
- R8: A result below zero gives ratioInt = 0 and ratioFrac = 0. A result above 2^42−1 gives all ones in both fields.
- R9: A captured halfPeriod of 0 behaves like 1, so every tick is a turnaround.
- R10: Cycles without a tick change neither the outputs nor the ramp state, whatever the inputs do.
- R11: The outputs show the effect of a tick on the clock edge that takes it, and are stable in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| outTick | input | 1 | One-cycle strobe per output clock |
| spreadEn | input | 1 | 1 = centre spread, 0 = static ratio |
| divInt | input | 12 | Integer part of the nominal ratio |
| divFrac | input | 30 | Fractional part of the nominal ratio |
| spreadOffset | input | 30 | Signed correction subtracted from the ratio |
| halfPeriod | input | 13 | Ticks per triangle leg |
| rampStep | input | 24 | Ramp increment per tick |
| ratioInt | output | 12 | Current integer ratio |
| ratioFrac | output | 30 | Current fractional ratio |

## Verification
The assertions assume that `outTick` is a single-cycle strobe sampled on `clk`, and that the configuration is a plain level with no handshake. They also assume that halfPeriod·rampStep stays small enough that the ramp accumulator never wraps. Stimulus keeps within these assumptions. Random half-periods stay below 41 and random steps stay within 24 bits, so the ramp cannot approach the accumulator limit. Configuration changes land mid-leg on purpose, and directed cases cover a zero half-period and both saturation limits.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int DefIntW    = 12;
  localparam int DefFracW   = 30;
  localparam int DefPeriodW = 13;
  localparam int DefStepW   = 24;

  // strobes from ramp control to the ratio datapath
  typedef struct packed {
    logic loadCfg;   // capture shadow configuration
    logic clearAcc;  // ramp value back to zero
    logic stepEn;    // apply one step
    logic stepUp;    // step direction
  } ssmStrobes_t;
endpackage

// File: rtl/ssm_ramp_ctrl.sv
module ssm_ramp_ctrl
  import ssm_pkg::*;
#(
  parameter int PERIOD_W = DefPeriodW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                outTick,
  input  logic                spreadEn,
  input  logic [PERIOD_W-1:0] halfPeriod,
  output ssmStrobes_t         stb
);
  logic                enQ;
  logic                dirUpQ;
  logic [PERIOD_W-1:0] periodQ;
  logic [PERIOD_W-1:0] cntQ;
  logic [PERIOD_W-1:0] lastCnt;
  logic                atEnd;
  logic                keepSpread;
  logic                loadCfg;

  assign lastCnt    = (periodQ == '0) ? '0 : periodQ - PERIOD_W'(1);
  assign atEnd      = (cntQ >= lastCnt);
  assign keepSpread = enQ & spreadEn;
  assign loadCfg    = outTick & (~enQ | atEnd);

  always_comb begin
    stb.loadCfg  = loadCfg;
    stb.clearAcc = loadCfg & ~keepSpread;
    stb.stepEn   = outTick & enQ & ~(loadCfg & ~keepSpread);
    stb.stepUp   = dirUpQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ     <= 1'b0;
      dirUpQ  <= 1'b1;
      periodQ <= '0;
      cntQ    <= '0;
    end else if (loadCfg) begin
      enQ     <= spreadEn;
      periodQ <= halfPeriod;
      if (keepSpread) begin
        cntQ   <= '0;
        dirUpQ <= ~dirUpQ;
      end else if (spreadEn) begin
        cntQ   <= halfPeriod >> 1;
        dirUpQ <= 1'b1;
      end else begin
        cntQ   <= '0;
        dirUpQ <= 1'b1;
      end
    end else if (outTick && enQ) begin
      cntQ <= cntQ + PERIOD_W'(1);
    end
  end

  // R10: idle cycles leave the ramp control untouched
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !outTick |=> ($stable(cntQ) && $stable(dirUpQ) && $stable(enQ)));

  // R5: the leg counter stays inside the captured half-period
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    enQ |-> (cntQ <= lastCnt));

  // R5: a turnaround that keeps spreading reverses the ramp
  p_turn_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (outTick && enQ && spreadEn && atEnd) |=> (dirUpQ != $past(dirUpQ)));

  // R2: with spreading off the counter is parked
  p_idle_park_r2: assert property (@(posedge clk) disable iff (rst)
    !enQ |-> (cntQ == '0 && dirUpQ));
endmodule

// File: rtl/ssm_ratio_path.sv
module ssm_ratio_path
  import ssm_pkg::*;
#(
  parameter int INT_W    = DefIntW,
  parameter int FRAC_W   = DefFracW,
  parameter int PERIOD_W = DefPeriodW,
  parameter int STEP_W   = DefStepW
) (
  input  logic              clk,
  input  logic              rst,
  input  ssmStrobes_t       stb,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic [FRAC_W-1:0] spreadOffset,
  input  logic [STEP_W-1:0] rampStep,
  output logic [INT_W-1:0]  ratioInt,
  output logic [FRAC_W-1:0] ratioFrac
);
  localparam int RATIO_W = INT_W + FRAC_W;
  localparam int ACC_W   = PERIOD_W + STEP_W + 1;
  localparam int WIDE_W  = (ACC_W > RATIO_W) ? ACC_W : RATIO_W;
  localparam int SUM_W   = WIDE_W + 2;

  logic [INT_W-1:0]  intQ;
  logic [FRAC_W-1:0] fracQ;
  logic [FRAC_W-1:0] offQ;
  logic [STEP_W-1:0] stepQ;
  logic [ACC_W-1:0]  accQ;
  logic [ACC_W-1:0]  stepExt;
  logic [SUM_W-1:0]  baseExt;
  logic [SUM_W-1:0]  offExt;
  logic [SUM_W-1:0]  accExt;
  logic [SUM_W-1:0]  sum;
  logic              isNeg;
  logic              isOver;
  logic [RATIO_W-1:0] ratioSat;

  assign stepExt = {{(ACC_W-STEP_W){1'b0}}, stepQ};

  always_ff @(posedge clk) begin
    if (rst) begin
      intQ  <= '0;
      fracQ <= '0;
      offQ  <= '0;
      stepQ <= '0;
      accQ  <= '0;
    end else begin
      if (stb.loadCfg) begin
        intQ  <= divInt;
        fracQ <= divFrac;
        offQ  <= spreadOffset;
        stepQ <= rampStep;
      end
      if (stb.clearAcc) begin
        accQ <= '0;
      end else if (stb.stepEn) begin
        accQ <= stb.stepUp ? accQ + stepExt : accQ - stepExt;
      end
    end
  end

  // two's complement sum over a range wide enough for any sign
  assign baseExt = {{(SUM_W-RATIO_W){1'b0}}, intQ, fracQ};
  assign offExt  = {{(SUM_W-FRAC_W){offQ[FRAC_W-1]}}, offQ};
  assign accExt  = {{(SUM_W-ACC_W){accQ[ACC_W-1]}}, accQ};
  assign sum     = baseExt - offExt + accExt;

  assign isNeg  = sum[SUM_W-1];
  assign isOver = |sum[SUM_W-2:RATIO_W];

  always_comb begin
    if (isNeg)       ratioSat = '0;
    else if (isOver) ratioSat = '1;
    else             ratioSat = sum[RATIO_W-1:0];
  end

  assign ratioInt  = ratioSat[RATIO_W-1:FRAC_W];
  assign ratioFrac = ratioSat[FRAC_W-1:0];

  // R2: a clear strobe leaves the ramp at zero
  p_acc_clear_r2: assert property (@(posedge clk) disable iff (rst)
    stb.clearAcc |=> (accQ == '0));

  // R6: shadow configuration moves only on a capture strobe
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !stb.loadCfg |=> ($stable(intQ) && $stable(fracQ) && $stable(offQ) && $stable(stepQ)));

  // R10: the ramp value moves only when a step or clear is issued
  p_acc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!stb.stepEn && !stb.clearAcc) |=> $stable(accQ));

  // R1: strobes never ask for a clear and a step together
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(stb.clearAcc && stb.stepEn));
endmodule

// File: rtl/ssm_modulator.sv
module ssm_modulator
  import ssm_pkg::*;
#(
  parameter int INT_W    = DefIntW,
  parameter int FRAC_W   = DefFracW,
  parameter int PERIOD_W = DefPeriodW,
  parameter int STEP_W   = DefStepW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                outTick,
  input  logic                spreadEn,
  input  logic [INT_W-1:0]    divInt,
  input  logic [FRAC_W-1:0]   divFrac,
  input  logic [FRAC_W-1:0]   spreadOffset,
  input  logic [PERIOD_W-1:0] halfPeriod,
  input  logic [STEP_W-1:0]   rampStep,
  output logic [INT_W-1:0]    ratioInt,
  output logic [FRAC_W-1:0]   ratioFrac
);
  ssmStrobes_t stb;

  ssm_ramp_ctrl #(.PERIOD_W(PERIOD_W)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .outTick    (outTick),
    .spreadEn   (spreadEn),
    .halfPeriod (halfPeriod),
    .stb        (stb)
  );

  ssm_ratio_path #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .PERIOD_W(PERIOD_W), .STEP_W(STEP_W)
  ) uPath (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .divInt       (divInt),
    .divFrac      (divFrac),
    .spreadOffset (spreadOffset),
    .rampStep     (rampStep),
    .ratioInt     (ratioInt),
    .ratioFrac    (ratioFrac)
  );
endmodule

// File: tb/ssm_modulator_test.sv
`timescale 1ns/1ps
module ssm_modulator_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        outTick;
  logic        spreadEn;
  logic [11:0] divInt;
  logic [29:0] divFrac;
  logic [29:0] spreadOffset;
  logic [12:0] halfPeriod;
  logic [23:0] rampStep;
  logic [11:0] ratioInt;
  logic [29:0] ratioFrac;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state kept by the bench
  bit     mEn;
  bit     mDir;
  int     mPer;
  int     mCnt;
  longint mAcc;
  longint mInt, mFrac, mOff, mStep;

  always #4 clk = ~clk;

  ssm_modulator uut (
    .clk(clk), .rst(rst), .outTick(outTick), .spreadEn(spreadEn),
    .divInt(divInt), .divFrac(divFrac), .spreadOffset(spreadOffset),
    .halfPeriod(halfPeriod), .rampStep(rampStep),
    .ratioInt(ratioInt), .ratioFrac(ratioFrac)
  );

  function automatic longint expRatio();
    longint off = (mOff >= (longint'(1) << 29)) ? mOff - (longint'(1) << 30) : mOff;
    longint v = (mInt << 30) + mFrac - off + mAcc;
    if (v < 0) v = 0;
    if (v > (longint'(1) << 42) - 1) v = (longint'(1) << 42) - 1;
    return v;
  endfunction

  task automatic modelTick();
    int  last = (mPer == 0) ? 0 : mPer - 1;
    bit  keep;
    if (mEn && mCnt < last) begin
      mAcc = mDir ? mAcc + mStep : mAcc - mStep;
      mCnt++;
    end else begin
      keep = mEn && spreadEn;
      if (keep) begin
        mAcc = mDir ? mAcc + mStep : mAcc - mStep;
        mCnt = 0;
        mDir = !mDir;
      end else begin
        mAcc = 0;
        mCnt = spreadEn ? int'(halfPeriod) / 2 : 0;
        mDir = 1;
      end
      mEn = spreadEn; mPer = int'(halfPeriod);
      mInt = longint'(divInt); mFrac = longint'(divFrac);
      mOff = longint'(spreadOffset); mStep = longint'(rampStep);
    end
  endtask

  task automatic checkVal(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint outVal();
    return (longint'(ratioInt) << 30) | longint'(ratioFrac);
  endfunction

  task automatic doTick(string tag);
    @(negedge clk);
    outTick = 1'b1;
    modelTick();
    @(negedge clk);
    outTick = 1'b0;
    checkVal(tag, outVal(), expRatio());
  endtask

  task automatic setCfg(bit en, int i, int f, int o, int p, int s);
    spreadEn = en; divInt = 12'(i); divFrac = 30'(f);
    spreadOffset = 30'(o); halfPeriod = 13'(p); rampStep = 24'(s);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint base;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; outTick = 1'b0;
    setCfg(0, 0, 0, 0, 0, 0);
    mEn = 0; mDir = 1; mPer = 0; mCnt = 0; mAcc = 0;
    mInt = 0; mFrac = 0; mOff = 0; mStep = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checkVal("R1 reset ratio", outVal(), 0);

    // R2 / R3 / R11: static ratio with positive then negative offset
    setCfg(0, 5, 100, 30, 77, 999);
    @(negedge clk);
    checkVal("R11 no change before tick", outVal(), 0);
    doTick("R2 static offset");
    checkVal("R2 literal", outVal(), (longint'(5) << 30) + 70);
    setCfg(0, 5, 100, (1 << 30) - 50, 3, 5);
    doTick("R3 negative offset");
    checkVal("R3 literal", outVal(), (longint'(5) << 30) + 150);

    // R7: borrow and carry through the fraction
    setCfg(0, 5, 10, 20, 0, 0);
    doTick("R7 borrow");
    checkVal("R7 borrow int", longint'(ratioInt), 4);
    setCfg(0, 5, (1 << 30) - 5, (1 << 30) - 10, 0, 0);
    doTick("R7 carry");
    checkVal("R7 carry literal", outVal(), (longint'(6) << 30) + 5);

    // R10: inputs move, no tick
    base = outVal();
    setCfg(1, 99, 1234, 7, 9, 9);
    repeat (4) @(negedge clk);
    checkVal("R10 idle hold", outVal(), base);

    // R8: saturation at both ends
    setCfg(0, 0, 0, 1, 0, 0);
    doTick("R8 low saturation");
    checkVal("R8 low literal", outVal(), 0);
    setCfg(0, 12'hfff, (1 << 30) - 1, (1 << 30) - 1, 0, 0);
    doTick("R8 high saturation");
    checkVal("R8 high literal", outVal(), (longint'(1) << 42) - 1);

    // R4 / R5: directed triangle, P=4, step 10, base frac 2^29
    setCfg(1, 100, 1 << 29, 0, 4, 10);
    doTick("R4 ramp start");
    checkVal("R4 start at zero", outVal(), (longint'(100) << 30) + (1 << 29));
    begin
      int accSeq[7] = '{10, 20, 10, 0, -10, -20, -10};
      foreach (accSeq[k]) begin
        doTick("R5 triangle");
        checkVal("R5 triangle literal", outVal(),
                 (longint'(100) << 30) + (1 << 29) + accSeq[k]);
      end
    end

    // R6: mid-leg change waits for the turnaround
    setCfg(1, 7, 1 << 29, 0, 4, 1);
    doTick("R6 held 1");
    checkVal("R6 int held", longint'(ratioInt), 100);
    doTick("R6 held 2");
    checkVal("R6 int still held", longint'(ratioInt), 100);
    doTick("R6 turnaround");
    checkVal("R6 int captured", longint'(ratioInt), 7);

    // R6: turnaround with spreading off stops the ramp
    spreadEn = 0;
    for (int k = 0; k < 8; k++) doTick("R6 stop at turnaround");
    checkVal("R6 ramp cleared", outVal(), (longint'(7) << 30) + (1 << 29));

    // R9: half-period of zero
    setCfg(1, 50, 1 << 28, 0, 0, 3);
    for (int k = 0; k < 6; k++) doTick("R9 zero period");

    // random mix (R2, R5, R6)
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        setCfg($urandom_range(0, 3) != 0, int'($urandom_range(0, 4095)),
               int'($urandom() & 32'h3fff_ffff), int'($urandom() & 32'h3fff_ffff),
               int'($urandom_range(0, 40)), int'($urandom() & 32'h00ff_ffff));
      end
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      doTick("R5 R6 random");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule